// File: doc/BRIEF.md
# Soft QAM Demapper

This block sits between channel compensation and the deinterleaver of an OFDM receiver. It takes one compensated complex data carrier at a time and turns it into the signed soft bit metrics that the deinterleaver consumes. How many metrics a carrier yields, and how they are formed, depends on the modulation of the current data field. The choices are binary and quaternary phase shift keying and 16- and 64-point QAM.

For the two QAM orders, the metrics beyond the first one per dimension come from piecewise-linear folding. A per-carrier scale S is multiplied by a fixed constant, and the magnitude of the previous metric is subtracted from the result. S combines the channel power term with the pilot amplitude term. It is computed once after the signal field and supplied alongside every carrier. The in-phase and quadrature dimensions are folded independently. The metrics leave one per clock on a registered stream with a valid strobe. While a carrier's metrics are still draining, the block holds off new carriers with a ready signal.

The modulation is picked up with the first carrier of each packet. It is then held for the rest of that packet, whatever the modulation input does.

Top module: `soft_qam_demapper`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and in_ready is 1. Until a packet start has been accepted, carriers are treated as BPSK.
- R2: With modulation code 0 (BPSK), an accepted carrier yields exactly one metric, sat(re).
- R3: With modulation code 1 (QPSK), an accepted carrier yields two metrics in the order sat(re), sat(im).
- R4: With modulation code 2 (16-QAM), an accepted carrier yields four metrics: sat(re), sat(t2-|re|), sat(im), sat(t2-|im|). Here t2 = floor(S*2591/4096).
- R5: With modulation code 3 (64-QAM), an accepted carrier yields six metrics: sat(x), sat(a), sat(t3-|a|), first for x=re and then for x=im. Here a = t2'-|x|, t2' = floor(S*2528/4096) and t3 = floor(S*1264/4096). Each intermediate is kept at full precision.
- R6: sat() clamps a value to the signed output range [-2^(W_OUT-1), 2^(W_OUT-1)-1].
- R7: The modulation is taken from in_mod only on an accepted carrier with in_first=1. That carrier and all later ones use it. in_mod on any other carrier has no effect.
- R8: The first metric of a carrier accepted at a clock edge is valid in the following cycle. The remaining metrics follow in consecutive cycles. in_ready is 1 exactly when no metric beyond the one currently shown is pending, so carriers can be accepted back to back without gaps.
- R9: A carrier presented while in_ready is 0 is dropped. This holds for its data, its in_first and its in_mod.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Carrier present |
| in_ready | output | 1 | Block can take a carrier this cycle |
| in_first | input | 1 | Carrier is the first of a packet |
| in_mod | input | 2 | Modulation code: 0 BPSK, 1 QPSK, 2 16-QAM, 3 64-QAM |
| in_re | input | W_IN | Compensated carrier, real part (signed) |
| in_im | input | W_IN | Compensated carrier, imaginary part (signed) |
| in_scale | input | W_S | Per-carrier scale S (unsigned) |
| out_valid | output | 1 | Metric valid |
| out_metric | output | W_OUT | Soft metric (signed) |

## Verification
The bench targets the points where each fold goes through zero. It also drives scales of 0 and full range, and real parts at the negative extreme. A design that mixed up the constants, floored wrongly or took the second fold from a saturated value would emit metrics off by a few counts in exactly these cases.

Inputs large enough to overflow the output range check the clamps. A wrapping adder would show a sign flip there.

Mid-packet changes of the modulation input test the latch. So do packet starts presented while the block is busy: a design that re-sampled there would change the metric count per carrier. Back-to-back carriers would expose a missing or duplicated beat at the seam between carriers.

// File: rtl/soft_demap_pkg.sv
package soft_demap_pkg;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'd0,
    MOD_QPSK  = 2'd1,
    MOD_QAM16 = 2'd2,
    MOD_QAM64 = 2'd3
  } mod_e;

  // fixed-point fold constants, 12 fractional bits
  localparam int FRAC      = 12;
  localparam int K_Q16     = 2591;  // 2/sqrt(10)
  localparam int K_Q64_HI  = 2528;  // 4/sqrt(42)
  localparam int K_Q64_LO  = 1264;  // 2/sqrt(42)

  // most metrics one carrier can produce (64-QAM, two dimensions)
  localparam int MAX_BEATS = 6;

endpackage

// File: rtl/demap_fold.sv
// One dimension of a carrier: the raw value and its folded metrics.
module demap_fold
  import soft_demap_pkg::*;
#(
  parameter int W_IN  = 12,
  parameter int W_S   = 12,
  parameter int W_ACC = 15
) (
  input  logic signed [W_IN-1:0]  x,
  input  logic        [W_S-1:0]   s,
  output logic signed [W_ACC-1:0] m_raw,
  output logic signed [W_ACC-1:0] m_q16,
  output logic signed [W_ACC-1:0] m_q64a,
  output logic signed [W_ACC-1:0] m_q64b
);
  localparam int W_P = W_S + FRAC;

  logic        [W_P-1:0]   p_q16, p_hi, p_lo;
  logic signed [W_ACC-1:0] t_q16, t_hi, t_lo;
  logic signed [W_ACC-1:0] x_ext, x_abs, a_abs;

  always_comb begin
    p_q16 = W_P'(s) * W_P'(K_Q16);
    p_hi  = W_P'(s) * W_P'(K_Q64_HI);
    p_lo  = W_P'(s) * W_P'(K_Q64_LO);
    t_q16 = W_ACC'(p_q16 >> FRAC);
    t_hi  = W_ACC'(p_hi >> FRAC);
    t_lo  = W_ACC'(p_lo >> FRAC);

    x_ext = W_ACC'(x);
    x_abs = x_ext[W_ACC-1] ? -x_ext : x_ext;

    m_raw  = x_ext;
    m_q16  = t_q16 - x_abs;
    m_q64a = t_hi - x_abs;
    a_abs  = m_q64a[W_ACC-1] ? -m_q64a : m_q64a;
    m_q64b = t_lo - a_abs;
  end
endmodule

// File: rtl/demap_order.sv
// Chooses which metrics a carrier emits and in what order: I before Q.
module demap_order
  import soft_demap_pkg::*;
#(
  parameter int W_ACC = 15,
  parameter int W_CNT = 3
) (
  input  mod_e                                mode,
  input  logic signed [W_ACC-1:0]             i_raw,
  input  logic signed [W_ACC-1:0]             i_q16,
  input  logic signed [W_ACC-1:0]             i_q64a,
  input  logic signed [W_ACC-1:0]             i_q64b,
  input  logic signed [W_ACC-1:0]             q_raw,
  input  logic signed [W_ACC-1:0]             q_q16,
  input  logic signed [W_ACC-1:0]             q_q64a,
  input  logic signed [W_ACC-1:0]             q_q64b,
  output logic [MAX_BEATS-1:0][W_ACC-1:0]     seq,
  output logic [W_CNT-1:0]                    count
);
  always_comb begin
    seq = '0;
    unique case (mode)
      MOD_BPSK: begin
        seq[0] = i_raw;
        count  = W_CNT'(1);
      end
      MOD_QPSK: begin
        seq[0] = i_raw;
        seq[1] = q_raw;
        count  = W_CNT'(2);
      end
      MOD_QAM16: begin
        seq[0] = i_raw;
        seq[1] = i_q16;
        seq[2] = q_raw;
        seq[3] = q_q16;
        count  = W_CNT'(4);
      end
      default: begin
        seq[0] = i_raw;
        seq[1] = i_q64a;
        seq[2] = i_q64b;
        seq[3] = q_raw;
        seq[4] = q_q64a;
        seq[5] = q_q64b;
        count  = W_CNT'(6);
      end
    endcase
  end
endmodule

// File: rtl/demap_sat.sv
// Clamp a wide signed value into the output range.
module demap_sat #(
  parameter int W_ACC = 15,
  parameter int W_OUT = 10
) (
  input  logic signed [W_ACC-1:0] din,
  output logic signed [W_OUT-1:0] dout
);
  localparam logic signed [W_ACC-1:0] HI = W_ACC'((64'sd1 <<< (W_OUT-1)) - 64'sd1);
  localparam logic signed [W_ACC-1:0] LO = -HI - W_ACC'(1);

  always_comb begin
    if (din > HI)      dout = HI[W_OUT-1:0];
    else if (din < LO) dout = LO[W_OUT-1:0];
    else               dout = din[W_OUT-1:0];
  end
endmodule

// File: rtl/soft_qam_demapper.sv
module soft_qam_demapper
  import soft_demap_pkg::*;
#(
  parameter int W_IN  = 12,
  parameter int W_S   = 12,
  parameter int W_OUT = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_first,
  input  logic [1:0]              in_mod,
  input  logic signed [W_IN-1:0]  in_re,
  input  logic signed [W_IN-1:0]  in_im,
  input  logic [W_S-1:0]          in_scale,
  output logic                    out_valid,
  output logic signed [W_OUT-1:0] out_metric
);
  localparam int W_ACC = ((W_S > W_IN) ? W_S : W_IN) + 3;
  localparam int W_CNT = $clog2(MAX_BEATS + 1);

  logic accept;
  mod_e mod_q, mode_now;

  assign accept   = in_valid && in_ready;
  assign mode_now = in_first ? mod_e'(in_mod) : mod_q;

  // packet modulation latch
  always_ff @(posedge clk) begin
    if (rst)                     mod_q <= MOD_BPSK;
    else if (accept && in_first) mod_q <= mod_e'(in_mod);
  end

  // per-dimension folding, same logic for I and Q
  logic signed [1:0][W_IN-1:0]  dim_in;
  logic [1:0][W_ACC-1:0] f_raw, f_q16, f_q64a, f_q64b;

  assign dim_in[0] = in_re;
  assign dim_in[1] = in_im;

  for (genvar d = 0; d < 2; d++) begin : g_dim
    demap_fold #(.W_IN(W_IN), .W_S(W_S), .W_ACC(W_ACC)) u_fold (
      .x      (dim_in[d]),
      .s      (in_scale),
      .m_raw  (f_raw[d]),
      .m_q16  (f_q16[d]),
      .m_q64a (f_q64a[d]),
      .m_q64b (f_q64b[d])
    );
  end

  logic [MAX_BEATS-1:0][W_ACC-1:0] seq_raw;
  logic [MAX_BEATS-1:0][W_OUT-1:0] seq_sat;
  logic [W_CNT-1:0]                seq_cnt;

  demap_order #(.W_ACC(W_ACC), .W_CNT(W_CNT)) u_order (
    .mode   (mode_now),
    .i_raw  (f_raw[0]),
    .i_q16  (f_q16[0]),
    .i_q64a (f_q64a[0]),
    .i_q64b (f_q64b[0]),
    .q_raw  (f_raw[1]),
    .q_q16  (f_q16[1]),
    .q_q64a (f_q64a[1]),
    .q_q64b (f_q64b[1]),
    .seq    (seq_raw),
    .count  (seq_cnt)
  );

  for (genvar b = 0; b < MAX_BEATS; b++) begin : g_sat
    demap_sat #(.W_ACC(W_ACC), .W_OUT(W_OUT)) u_sat (
      .din  ($signed(seq_raw[b])),
      .dout (seq_sat[b])
    );
  end

  // serializer: shown beat in out_q, pending beats in hold_q
  logic [MAX_BEATS-1:0][W_OUT-1:0] hold_q;
  logic [W_CNT-1:0]                rem_q;
  logic                            vld_q;
  logic [W_OUT-1:0]                out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rem_q  <= '0;
      vld_q  <= 1'b0;
      out_q  <= '0;
    end else if (accept) begin
      out_q <= seq_sat[0];
      for (int i = 0; i < MAX_BEATS - 1; i++) hold_q[i] <= seq_sat[i+1];
      hold_q[MAX_BEATS-1] <= '0;
      rem_q <= seq_cnt - W_CNT'(1);
      vld_q <= 1'b1;
    end else if (rem_q != '0) begin
      out_q <= hold_q[0];
      for (int i = 0; i < MAX_BEATS - 1; i++) hold_q[i] <= hold_q[i+1];
      hold_q[MAX_BEATS-1] <= '0;
      rem_q <= rem_q - W_CNT'(1);
      vld_q <= 1'b1;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign in_ready   = (rem_q == '0);
  assign out_valid  = vld_q;
  assign out_metric = $signed(out_q);

endmodule

// File: rtl/soft_qam_demapper_chk.sv
module soft_qam_demapper_chk #(
  parameter int W_IN  = 12,
  parameter int W_OUT = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_first,
  input logic [1:0]              in_mod,
  input logic signed [W_IN-1:0]  in_re,
  input logic                    out_valid,
  input logic signed [W_OUT-1:0] out_metric,
  input logic [1:0]              mod_q
);
  localparam int HI = (1 <<< (W_OUT-1)) - 1;
  localparam int LO = -HI - 1;

  logic take, re_fits;
  assign take    = in_valid && in_ready;
  assign re_fits = (int'(in_re) <= HI) && (int'(in_re) >= LO);

  assert_bpsk_single_R2: assert property (@(posedge clk) disable iff (rst)
    (take && in_first && in_mod == 2'd0) |=> (out_valid && in_ready));

  assert_bpsk_value_R2: assert property (@(posedge clk) disable iff (rst)
    (take && in_first && in_mod == 2'd0 && re_fits) |=> (int'(out_metric) == $past(int'(in_re))));

  assert_qpsk_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (take && in_first && in_mod == 2'd1) |=> !in_ready);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_ready) |=> out_valid);

  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_mod_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(take && in_first) |=> $stable(mod_q));
endmodule

bind soft_qam_demapper soft_qam_demapper_chk #(.W_IN(W_IN), .W_OUT(W_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_first   (in_first),
  .in_mod     (in_mod),
  .in_re      (in_re),
  .out_valid  (out_valid),
  .out_metric (out_metric),
  .mod_q      (mod_q)
);

// File: tb/soft_qam_demapper_test.sv
module soft_qam_demapper_test;
  localparam int W_IN  = 12;
  localparam int W_S   = 12;
  localparam int W_OUT = 10;
  localparam int HI    = (1 <<< (W_OUT-1)) - 1;
  localparam int LO    = -HI - 1;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_first, out_valid;
  logic [1:0] in_mod;
  logic signed [W_IN-1:0] in_re, in_im;
  logic [W_S-1:0] in_scale;
  logic signed [W_OUT-1:0] out_metric;

  always #4 clk = ~clk;  // 125 MHz

  soft_qam_demapper #(.W_IN(W_IN), .W_S(W_S), .W_OUT(W_OUT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_mod(in_mod), .in_re(in_re), .in_im(in_im),
    .in_scale(in_scale), .out_valid(out_valid), .out_metric(out_metric)
  );

  int    n_run = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    ref_mod = 0;
  bit    dropped = 1'b0;
  bit    done = 1'b0;

  function automatic int sat(int v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  function automatic int mag(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic push(int v, string tag);
    exp_q.push_back(sat(v));
    tag_q.push_back((v > HI || v < LO) ? {tag, " R6"} : tag);
  endtask

  task automatic model_carrier(int m, int re, int im, int s, string extra);
    string t;
    int t2, t2b, t3, a;
    t = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
    t = {t, extra};
    t2  = (s * 2591) / 4096;
    t2b = (s * 2528) / 4096;
    t3  = (s * 1264) / 4096;
    for (int d = 0; d < 2; d++) begin
      int x;
      x = (d == 0) ? re : im;
      if (m == 0 && d == 1) break;
      push(x, t);
      if (m == 2) push(t2 - mag(x), t);
      if (m == 3) begin
        a = t2b - mag(x);
        push(a, t);
        push(t3 - mag(a), t);
      end
    end
  endtask

  // one cycle: check outputs, then drive the next input and update the model
  task automatic step(bit v, bit first, int m, int re, int im, int s);
    bit exp_v, rdy;
    @(negedge clk);
    exp_v = (exp_q.size() > 0);
    rdy   = (exp_q.size() <= 1);
    check(out_valid == exp_v, "R8 out_valid", int'(out_valid), int'(exp_v));
    check(in_ready == rdy, "R8 in_ready", int'(in_ready), int'(rdy));
    if (exp_v) begin
      check(int'(out_metric) == exp_q[0], tag_q[0], int'(out_metric), exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    in_valid = v;
    in_first = first;
    in_mod   = 2'(m);
    in_re    = W_IN'(re);
    in_im    = W_IN'(im);
    in_scale = W_S'(s);
    if (v && rdy) begin
      string extra;
      int eff;
      extra = "";
      if (!first && m != ref_mod) extra = {extra, " R7"};
      if (dropped && !first) extra = {extra, " R9"};
      if (first) begin
        ref_mod = m;
        dropped = 1'b0;
      end
      eff = ref_mod;
      model_carrier(eff, re, im, s, extra);
    end else if (v && first && m != ref_mod) begin
      dropped = 1'b1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_first = 1'b0; in_mod = 2'd0;
    in_re = '0; in_im = '0; in_scale = '0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R1: default BPSK before any packet start
    step(1'b1, 1'b0, 3, 77, 5, 100);
    idle(2);
    // R2 BPSK, including clamp (R6)
    step(1'b1, 1'b1, 0, 100, 9, 50);
    step(1'b1, 1'b0, 0, -700, 9, 50);
    step(1'b1, 1'b0, 0, -2048, 0, 0);
    idle(2);
    // R3 QPSK
    step(1'b1, 1'b1, 1, -5, 600, 10);
    step(1'b1, 1'b0, 1, 511, -512, 10);
    idle(4);
    // R4 16-QAM around the fold and at scale extremes
    step(1'b1, 1'b1, 2, 300, -700, 1000);
    step(1'b1, 1'b0, 2, 632, -632, 1000);
    step(1'b1, 1'b0, 2, 2000, -2048, 4095);
    step(1'b1, 1'b0, 2, 3, -3, 0);
    idle(10);
    // R5 64-QAM
    step(1'b1, 1'b1, 3, 100, -300, 2000);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 3, 1234 - i * 50, 617 + i * 40, 2000 - i * 100);
    // R7: modulation input changes mid-packet with no packet start
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, i % 3, 40 * i - 160, 300 - 60 * i, 3000);
    // R9: packet start offered while busy is dropped
    step(1'b1, 1'b1, 0, 1, 1, 1);
    step(1'b1, 1'b1, 1, 2, 2, 2);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, 10 * i, -10 * i, 4095);
    idle(8);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      bit v, f;
      v = ($urandom_range(0, 9) < 7);
      f = ($urandom_range(0, 7) == 0);
      step(v, f, int'($urandom_range(0, 3)), int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)));
    end
    idle(10);
    finish_run();
  end
endmodule